// File: doc/BRIEF.md
# Signalling Voltage Switch Sequencer

This block runs the controller side of the move from 3.3 V to 1.8 V signalling on an SD card bus. The card first answers the operating-condition query. If that answer says the card has high capacity and accepts 1.8 V, the sequencer asks the command engine to send the voltage-switch command. It then stops the card clock and checks that the card pulls every data line low. Next it enables the 1.8 V signalling level and lets it settle for 5 ms. It restarts the clock and waits a further 1 ms, then checks that the card releases all data lines high.

Every step reports to the rest of the controller through plain handshake signals. The command engine, the regulator and the pads stay outside the block. A fault anywhere in the switch phase ends the sequence. The block then removes card power, gates the clock and asks for re-initialisation with the 1.8 V request withdrawn. An error flag in the command response ends the sequence with an I/O error instead. The settle windows are counted in core clock cycles derived from the `CLK_HZ` parameter.

Top module: `uv_volt_switch`

## Requirements
- R1: After reset, card power enable and card clock enable are 1. The 1.8 V enable, the command request, done, success, retry and ioerr are all 0.
- R2: A start pulse is accepted only while the block is idle, and only when bit 30 and bit 24 of the response word are both 1. Any other start pulse is ignored: no command request is raised and no output changes.
- R3: On an accepted start, the command request rises in the next cycle. It stays high until the cycle in which command-done is seen. If command-error is 1 in that cycle, the sequence ends with done and ioerr. Power and clock stay 1 and the 1.8 V enable stays 0.
- R4: If command-done arrives without an error, card clock enable goes to 0 in the next cycle.
- R5: DAT[3:0] passes through a two-flop synchroniser. The block takes one sample 4 cycles after the clock stops. A value other than 0000 is a failure.
- R6: After the zero check passes, the 1.8 V enable is set while the clock is still stopped. It is then held for CLK_HZ/200 cycles before it is checked, and the clock enable rises exactly that many cycles after the 1.8 V enable.
- R7: A regulator fault in any cycle of the 5 ms window clears the 1.8 V enable in the next cycle. The window still runs to its end, and the sequence then fails. A fault outside the window has no effect.
- R8: After the clock restarts, the block takes one sample CLK_HZ/1000 cycles later. If it reads 1111, done and success pulse together.
- R9: Any failure in R5, R7 or R8 drives power enable, clock enable and the 1.8 V enable to 0, and pulses done with retry.
- R10: done lasts one cycle and comes with exactly one of success, retry or ioerr. None of the three appears without done.
- R11: An accepted start restores power enable and clock enable to 1 and the 1.8 V enable to 0, even after an earlier retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin the switch sequence |
| acmd41_resp_i | input | 32 | Operating-condition response word from the card |
| cmd11_req_o | output | 1 | Request to the command engine for the voltage-switch command, argument zero |
| cmd11_done_i | input | 1 | Command engine finished the voltage-switch command |
| cmd11_err_i | input | 1 | Error flag of that response, valid with done |
| dat_lvl_i | input | 4 | Raw DAT[3:0] line levels |
| v18_fault_i | input | 1 | Regulator status: 1 drops the 1.8 V enable during the settle window |
| card_clk_en_o | output | 1 | Card clock enable |
| sig18_en_o | output | 1 | 1.8 V signalling enable |
| card_pwr_en_o | output | 1 | Card power enable |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| success_o | output | 1 | Switch completed |
| retry_o | output | 1 | Re-initialise without the 1.8 V request |
| ioerr_o | output | 1 | Voltage-switch command reported an error |

## Verification
The assertions assume that command-done arrives only while the command request is high, as a single-cycle pulse. They also assume the data lines are held steady around each sample point, so the synchroniser delay does not move the result. The stimulus respects both assumptions. It answers the command request after a fixed delay with a one-cycle done. It changes the line levels only when the clock enable changes, well away from the sample edges. It places regulator faults on chosen cycles of the window, including its first and last cycles.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_STOP,
        ST_V18,
        ST_ON
    } vsw_state_e;

    typedef struct packed {
        logic ok;
        logic retry;
        logic ioerr;
    } vsw_result_t;

    localparam int RESP_CCS_BIT  = 30;
    localparam int RESP_S18A_BIT = 24;

    function automatic logic resp_allows_switch(input logic [31:0] resp);
        return resp[RESP_CCS_BIT] & resp[RESP_S18A_BIT];
    endfunction

    function automatic int cycles_for(input int hz, input int per_second);
        return hz / per_second;
    endfunction

endpackage

// File: rtl/vsw_dat_sync.sv
module vsw_dat_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= d_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/vsw_wait_timer.sv
module vsw_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/vsw_ctrl.sv
module vsw_ctrl
    import vsw_pkg::*;
#(
    parameter int CW         = 8,
    parameter int SETTLE_CYC = 4,
    parameter int T5_CYC     = 100,
    parameter int T1_CYC     = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [31:0]   resp_i,
    input  logic          cmd_done_i,
    input  logic          cmd_err_i,
    input  logic [3:0]    dat_s_i,
    input  logic          fault_i,
    input  logic          t_zero_i,
    output logic          t_load_o,
    output logic [CW-1:0] t_val_o,
    output logic          cmd_o,
    output logic          clk_en_o,
    output logic          sig18_o,
    output logic          pwr_o,
    output logic          done_o,
    output vsw_result_t   res_o
);
    vsw_state_e state_q;
    logic chk_stop, chk_v18, chk_on;
    logic pass_stop, pass_v18, pass_on;
    logic fail_now, cmd_ok;

    always_comb begin
        chk_stop  = (state_q == ST_STOP) && t_zero_i;
        chk_v18   = (state_q == ST_V18)  && t_zero_i;
        chk_on    = (state_q == ST_ON)   && t_zero_i;
        pass_stop = (dat_s_i == 4'b0000);
        pass_v18  = sig18_o && !fault_i;
        pass_on   = (dat_s_i == 4'b1111);
        fail_now  = (chk_stop && !pass_stop) || (chk_v18 && !pass_v18) ||
                    (chk_on && !pass_on);
        cmd_ok    = (state_q == ST_CMD) && cmd_done_i && !cmd_err_i;

        t_load_o = 1'b0;
        t_val_o  = '0;
        if (cmd_ok) begin
            t_load_o = 1'b1;
            t_val_o  = CW'(SETTLE_CYC - 1);
        end else if (chk_stop && pass_stop) begin
            t_load_o = 1'b1;
            t_val_o  = CW'(T5_CYC - 1);
        end else if (chk_v18 && pass_v18) begin
            t_load_o = 1'b1;
            t_val_o  = CW'(T1_CYC - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cmd_o    <= 1'b0;
            clk_en_o <= 1'b1;
            sig18_o  <= 1'b0;
            pwr_o    <= 1'b1;
            done_o   <= 1'b0;
            res_o    <= '0;
        end else begin
            done_o <= 1'b0;
            res_o  <= '0;
            if (fail_now) begin
                state_q     <= ST_IDLE;
                pwr_o       <= 1'b0;
                clk_en_o    <= 1'b0;
                sig18_o     <= 1'b0;
                done_o      <= 1'b1;
                res_o.retry <= 1'b1;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (start_i && resp_allows_switch(resp_i)) begin
                            state_q  <= ST_CMD;
                            cmd_o    <= 1'b1;
                            pwr_o    <= 1'b1;
                            clk_en_o <= 1'b1;
                            sig18_o  <= 1'b0;
                        end
                    end
                    ST_CMD: begin
                        if (cmd_done_i) begin
                            cmd_o <= 1'b0;
                            if (cmd_err_i) begin
                                state_q     <= ST_IDLE;
                                done_o      <= 1'b1;
                                res_o.ioerr <= 1'b1;
                            end else begin
                                state_q  <= ST_STOP;
                                clk_en_o <= 1'b0;
                            end
                        end
                    end
                    ST_STOP: begin
                        if (chk_stop) begin
                            state_q <= ST_V18;
                            sig18_o <= 1'b1;
                        end
                    end
                    ST_V18: begin
                        if (fault_i) begin
                            sig18_o <= 1'b0;
                        end
                        if (chk_v18) begin
                            state_q  <= ST_ON;
                            clk_en_o <= 1'b1;
                        end
                    end
                    ST_ON: begin
                        if (chk_on) begin
                            state_q  <= ST_IDLE;
                            done_o   <= 1'b1;
                            res_o.ok <= 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R10
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $onehot({res_o.ok, res_o.retry, res_o.ioerr}));
    // R10
    result_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        (res_o != '0) |-> done_o);
    // R9
    power_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_o) |-> res_o.retry);
    // R6
    v18_clock_off_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sig18_o) |-> !clk_en_o);
    // R3
    cmd_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_o) |-> $past(cmd_done_i));
    // R7
    fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_i && state_q == ST_V18) |=> !sig18_o);
    // R8
    success_levels_chk: assert property (@(posedge clk) disable iff (rst)
        res_o.ok |-> (sig18_o && clk_en_o && pwr_o));
endmodule

// File: rtl/uv_volt_switch.sv
module uv_volt_switch
    import vsw_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] acmd41_resp_i,
    output logic        cmd11_req_o,
    input  logic        cmd11_done_i,
    input  logic        cmd11_err_i,
    input  logic [3:0]  dat_lvl_i,
    input  logic        v18_fault_i,
    output logic        card_clk_en_o,
    output logic        sig18_en_o,
    output logic        card_pwr_en_o,
    output logic        done_o,
    output logic        success_o,
    output logic        retry_o,
    output logic        ioerr_o
);
    localparam int T5_CYC     = cycles_for(CLK_HZ, 200);
    localparam int T1_CYC     = cycles_for(CLK_HZ, 1000);
    localparam int SETTLE_CYC = SYNC_STAGES + 2;
    localparam int CW         = $clog2(T5_CYC + 1);

    logic [3:0]    dat_s;
    logic          t_load, t_zero;
    logic [CW-1:0] t_val;
    vsw_result_t   res;

    vsw_dat_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (dat_lvl_i),
        .q_o (dat_s)
    );

    vsw_wait_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (t_load),
        .load_val_i (t_val),
        .zero_o     (t_zero)
    );

    vsw_ctrl #(
        .CW(CW), .SETTLE_CYC(SETTLE_CYC), .T5_CYC(T5_CYC), .T1_CYC(T1_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .resp_i     (acmd41_resp_i),
        .cmd_done_i (cmd11_done_i),
        .cmd_err_i  (cmd11_err_i),
        .dat_s_i    (dat_s),
        .fault_i    (v18_fault_i),
        .t_zero_i   (t_zero),
        .t_load_o   (t_load),
        .t_val_o    (t_val),
        .cmd_o      (cmd11_req_o),
        .clk_en_o   (card_clk_en_o),
        .sig18_o    (sig18_en_o),
        .pwr_o      (card_pwr_en_o),
        .done_o     (done_o),
        .res_o      (res)
    );

    assign success_o = res.ok;
    assign retry_o   = res.retry;
    assign ioerr_o   = res.ioerr;
endmodule

// File: tb/uv_volt_switch_test.sv
module uv_volt_switch_test;
    localparam int CLK_HZ = 20_000;
    localparam int T5 = CLK_HZ / 200;
    localparam int T1 = CLK_HZ / 1000;
    localparam int SETTLE = 4;
    localparam logic [31:0] GOOD_RESP = 32'h4100_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [31:0] acmd41_resp_i = '0;
    logic cmd11_req_o, cmd11_done_i = 1'b0, cmd11_err_i = 1'b0;
    logic [3:0] dat_lvl_i = 4'h0;
    logic v18_fault_i = 1'b0;
    logic card_clk_en_o, sig18_en_o, card_pwr_en_o;
    logic done_o, success_o, retry_o, ioerr_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    uv_volt_switch #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .acmd41_resp_i(acmd41_resp_i),
        .cmd11_req_o(cmd11_req_o), .cmd11_done_i(cmd11_done_i),
        .cmd11_err_i(cmd11_err_i), .dat_lvl_i(dat_lvl_i),
        .v18_fault_i(v18_fault_i), .card_clk_en_o(card_clk_en_o),
        .sig18_en_o(sig18_en_o), .card_pwr_en_o(card_pwr_en_o),
        .done_o(done_o), .success_o(success_o), .retry_o(retry_o),
        .ioerr_o(ioerr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 command, 2 clock stopped,
    // 3 settle window, 4 clock restarted
    int m_phase, m_left;
    bit m_cmd, m_clk, m_s18, m_pwr, m_done, m_ok, m_retry, m_io;
    logic [3:0] hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_left = 0;
            m_cmd = 0; m_clk = 1; m_s18 = 0; m_pwr = 1;
            m_done = 0; m_ok = 0; m_retry = 0; m_io = 0;
            hist = {4'h0, 4'h0};
        end else begin
            logic [3:0] seen;
            bit fail;
            seen = hist[1];
            hist.push_front(dat_lvl_i);
            void'(hist.pop_back());
            m_done = 0; m_ok = 0; m_retry = 0; m_io = 0;
            fail = 0;
            if (m_phase == 0) begin
                if (start_i && acmd41_resp_i[30] && acmd41_resp_i[24]) begin
                    m_phase = 1; m_cmd = 1; m_pwr = 1; m_clk = 1; m_s18 = 0;
                end
            end else if (m_phase == 1) begin
                if (cmd11_done_i) begin
                    m_cmd = 0;
                    if (cmd11_err_i) begin
                        m_phase = 0; m_done = 1; m_io = 1;
                    end else begin
                        m_phase = 2; m_clk = 0; m_left = SETTLE;
                    end
                end
            end else if (m_phase == 2) begin
                if (m_left == 1) begin
                    if (seen == 4'h0) begin
                        m_phase = 3; m_s18 = 1; m_left = T5;
                    end else fail = 1;
                end else m_left--;
            end else if (m_phase == 3) begin
                bit was;
                was = m_s18;
                if (v18_fault_i) m_s18 = 0;
                if (m_left == 1) begin
                    if (was && !v18_fault_i) begin
                        m_phase = 4; m_clk = 1; m_left = T1;
                    end else fail = 1;
                end else m_left--;
            end else begin
                if (m_left == 1) begin
                    if (seen == 4'hF) begin
                        m_phase = 0; m_done = 1; m_ok = 1;
                    end else fail = 1;
                end else m_left--;
            end
            if (fail) begin
                m_phase = 0; m_pwr = 0; m_clk = 0; m_s18 = 0;
                m_done = 1; m_retry = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(cmd11_req_o == m_cmd, "R3 cmd request", cmd11_req_o, m_cmd);
            chk(card_clk_en_o == m_clk, "R4 clock enable", card_clk_en_o, m_clk);
            chk(sig18_en_o == m_s18, "R6 1.8V enable", sig18_en_o, m_s18);
            chk(card_pwr_en_o == m_pwr, "R9 power enable", card_pwr_en_o, m_pwr);
            chk(done_o == m_done, "R10 done", done_o, m_done);
            chk(success_o == m_ok, "R8 success", success_o, m_ok);
            chk(retry_o == m_retry, "R9 retry", retry_o, m_retry);
            chk(ioerr_o == m_io, "R3 ioerr", ioerr_o, m_io);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150_000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic ignored_start(input logic [31:0] resp);
        @(negedge clk);
        start_i = 1; acmd41_resp_i = resp;
        @(negedge clk);
        start_i = 0;
        for (int i = 0; i < 8; i++) begin
            chk(cmd11_req_o == 0, "R2 ignored start", cmd11_req_o, 0);
            @(negedge clk);
        end
    endtask

    // code: 0 success, 1 retry, 2 ioerr
    task automatic run_case(input logic [3:0] lo, input logic [3:0] hi,
                            input bit err, input int fault_at,
                            input bit busy_poke, input int code, input string tag);
        int n = 0, t_s18 = 0, t_clk = 0;
        bit s18_seen = 0, clk_seen = 0;
        @(negedge clk);
        dat_lvl_i = lo; start_i = 1; acmd41_resp_i = GOOD_RESP;
        @(negedge clk);
        start_i = 0;
        chk(card_pwr_en_o == 1, {"R11 power restored ", tag}, card_pwr_en_o, 1);
        chk(card_clk_en_o == 1, {"R11 clock restored ", tag}, card_clk_en_o, 1);
        chk(cmd11_req_o == 1, {"R3 request raised ", tag}, cmd11_req_o, 1);
        repeat (3) @(negedge clk);
        cmd11_done_i = 1; cmd11_err_i = err;
        @(negedge clk);
        cmd11_done_i = 0; cmd11_err_i = 0;
        if (!err) chk(card_clk_en_o == 0, {"R4 clock stopped ", tag}, card_clk_en_o, 0);
        while (1) begin
            v18_fault_i = 0; start_i = 0;
            if (done_o) break;
            if (sig18_en_o && !s18_seen) begin
                s18_seen = 1; n = 0; t_s18 = cyc;
            end else if (s18_seen) n++;
            if (s18_seen && fault_at >= 0 && n == fault_at) v18_fault_i = 1;
            if (busy_poke && s18_seen && n == 5) begin
                start_i = 1; acmd41_resp_i = GOOD_RESP;
            end
            if (card_clk_en_o && s18_seen && !clk_seen) begin
                clk_seen = 1; t_clk = cyc; dat_lvl_i = hi;
            end
            @(negedge clk);
        end
        chk(success_o == (code == 0), {"R8 result ok ", tag}, success_o, code == 0);
        chk(retry_o == (code == 1), {"R9 result retry ", tag}, retry_o, code == 1);
        chk(ioerr_o == (code == 2), {"R3 result ioerr ", tag}, ioerr_o, code == 2);
        if (code == 0) begin
            chk(t_clk - t_s18 == T5, {"R6 window length ", tag}, t_clk - t_s18, T5);
            chk(cyc - t_clk == T1, {"R8 restart wait ", tag}, cyc - t_clk, T1);
        end
        if (code == 1) begin
            chk(card_pwr_en_o == 0, {"R9 power off ", tag}, card_pwr_en_o, 0);
            chk(sig18_en_o == 0, {"R9 1.8V off ", tag}, sig18_en_o, 0);
        end
        if (code == 2) begin
            chk(card_pwr_en_o == 1 && card_clk_en_o == 1 && sig18_en_o == 0,
                {"R3 levels after ioerr ", tag}, {card_pwr_en_o, card_clk_en_o, sig18_en_o}, 3'b110);
        end
        @(negedge clk);
        chk(done_o == 0, {"R10 single-cycle done ", tag}, done_o, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(card_pwr_en_o == 1, "R1 power", card_pwr_en_o, 1);
        chk(card_clk_en_o == 1, "R1 clock", card_clk_en_o, 1);
        chk(sig18_en_o == 0, "R1 1.8V", sig18_en_o, 0);
        chk(cmd11_req_o == 0, "R1 request", cmd11_req_o, 0);
        chk(done_o == 0 && success_o == 0 && retry_o == 0 && ioerr_o == 0,
            "R1 results", done_o, 0);
        rst = 0;
        repeat (3) @(negedge clk);

        ignored_start(32'h4000_0000);   // R2 missing bit 24
        ignored_start(32'h0100_0000);   // R2 missing bit 30
        ignored_start(32'hBEFF_FFFF);   // R2 neither bit

        run_case(4'h0, 4'hF, 0, -1, 0, 0, "clean");
        // R7 fault outside the window is ignored
        @(negedge clk); v18_fault_i = 1;
        @(negedge clk); v18_fault_i = 0;
        repeat (2) @(negedge clk);
        chk(sig18_en_o == 1, "R7 fault outside window", sig18_en_o, 1);

        run_case(4'h0, 4'hF, 0, -1, 1, 0, "busy start");      // R2
        run_case(4'h0, 4'hF, 1, -1, 0, 2, "cmd error");       // R3
        run_case(4'h1, 4'hF, 0, -1, 0, 1, "lines not low");   // R5
        run_case(4'h0, 4'hF, 0, 0, 0, 1, "fault first");      // R7
        run_case(4'h0, 4'hF, 0, 40, 0, 1, "fault middle");    // R7
        run_case(4'h0, 4'hF, 0, T5-1, 0, 1, "fault last");    // R7
        run_case(4'h0, 4'h7, 0, -1, 0, 1, "lines not high");  // R8
        run_case(4'h0, 4'hF, 0, -1, 0, 0, "after retry");     // R11

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule